// File: doc/BRIEF.md
# Gated Dual-Character Serializer

This block turns a 20-bit parallel word, made of two 10-bit line-coded characters, into a serial bit stream. It runs entirely in the fast bit-clock domain. A one-cycle word strobe marks every twentieth bit slot. That strobe stands for the rising edge of the slow word clock, and on it the block captures the parallel word. From the next cycle on, one bit leaves per clock. Bit 0 goes first and bit 19 goes last, so the lower character (bits 0 to 9, line-code positions a through j from the lowest index upward) is sent before the upper character (bits 10 to 19).

Two controls gate the transmitter: an active-low enable (`tx_en_n`) and a loopback request (`wrap_req`). If either is high when a word is strobed, that word is dropped. For the whole of that word slot the output pair then sits at its idle level: true output high, complement output low. The controls are looked at only at word boundaries, so a character is never cut short or started partway through. The output is modelled as a true/complement pair, and the complement is always the inverse of the true output.

The control is a two-state machine. In `ST_IDLE` the pair is held at idle. In `ST_SEND` the shift register drives the pair. The transitions are:
- `T_START`: from `ST_IDLE` to `ST_SEND`, on a strobe while enabled.
- `T_NEXT`: from `ST_SEND` to `ST_SEND`, on a strobe while enabled. The new word is loaded.
- `T_STOP`: from `ST_SEND` to `ST_IDLE`, on a strobe while blocked.
- `T_DRAIN`: from `ST_SEND` to `ST_IDLE`, when the 20th bit has been sent and no new strobe has come.

Top module: `ser20_tx`

## Requirements
- R1: While reset is asserted, and right after it is released, `ser_p` is 1 and `ser_n` is 0.
- R2: A word strobed while `tx_en_n`=0 and `wrap_req`=0 is captured on that clock edge. Its bit 0 appears on `ser_p` in the very next cycle, one bit period after capture.
- R3: The captured word leaves one bit per clock in index order 0,1,...,19. Bits 0-9 (the first character) precede bits 10-19 (the second character).
- R4: Strobes spaced exactly 20 cycles apart produce a continuous stream: bit 19 of one word is followed directly by bit 0 of the next.
- R5: If `tx_en_n`=1 or `wrap_req`=1 at a strobe, then for the following 20 cycles `ser_p`=1 and `ser_n`=0.
- R6: A word strobed while blocked is discarded. The next word sent after re-enable is the word given at that later strobe.
- R7: Changes on `tx_en_n` between strobes have no effect until the next strobe. A word in flight completes, and an idle slot stays idle.
- R8: If no strobe follows the 20th bit, `ser_p` returns to 1 from the next cycle onward.
- R9: `ser_n` is always the bitwise inverse of `ser_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_stb | input | 1 | One-cycle word boundary strobe, every 20 clocks |
| tx_word | input | 20 | Parallel word, bit 0 sent first |
| tx_en_n | input | 1 | Active-low transmit enable |
| wrap_req | input | 1 | Loopback request; high blocks transmission |
| ser_p | output | 1 | Serial data, true side (idle high) |
| ser_n | output | 1 | Serial data, complement side (idle low) |

## Verification
The bench sends words whose bit 0, bit 19 or comma-like first character would show up immediately if the bit order were reversed or the characters swapped, or if the output lagged by a cycle. It drops a blocked word and then sends a fresh one: a design that queued the blocked word would put the stale data on the line. It also toggles the enable in the middle of a word, both while a word is running and while a slot is idle. A design that sampled the enable every cycle would truncate the running character or start sending partway through the idle one. Finally it lets a word run out with no follow-up strobe, which catches a design that keeps shifting residue out instead of returning to idle high.

// File: rtl/ser20_pkg.sv
package ser20_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/ser20_gate_fsm.sv
module ser20_gate_fsm
    import ser20_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_stb,
    input  logic tx_en_n,
    input  logic wrap_req,
    input  logic cnt_last,
    output logic load,
    output logic shift_en,
    output logic drive
);
    tx_state_e state, state_nx;
    logic      permit;

    assign permit = !tx_en_n && !wrap_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (word_stb && permit) state_nx = ST_SEND;   // T_START
            ST_SEND: begin
                if (word_stb) state_nx = permit ? ST_SEND : ST_IDLE; // T_NEXT / T_STOP
                else if (cnt_last) state_nx = ST_IDLE;             // T_DRAIN
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = word_stb && permit;
        shift_en = (state == ST_SEND) && !word_stb;
        drive    = (state == ST_SEND);
    end
endmodule

// File: rtl/ser20_bitcnt.sv
module ser20_bitcnt #(
    parameter int WORD_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (step && !last) cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_V);
endmodule

// File: rtl/ser20_shift.sv
module ser20_shift #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic              head
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr <= '1;
        else if (load)     sr <= din;
        else if (shift_en) sr <= {1'b1, sr[WORD_W-1:1]};
    end

    assign head = sr[0];
endmodule

// File: rtl/ser20_tx.sv
module ser20_tx #(
    parameter int CHAR_W = 10,
    parameter int CHARS  = 2,
    parameter int WORD_W = CHAR_W * CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_en_n,
    input  logic              wrap_req,
    output logic              ser_p,
    output logic              ser_n
);
    logic load, shift_en, drive, cnt_last, head;

    ser20_gate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .tx_en_n(tx_en_n),
        .wrap_req(wrap_req), .cnt_last(cnt_last), .load(load),
        .shift_en(shift_en), .drive(drive)
    );

    ser20_bitcnt #(.WORD_W(WORD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(word_stb), .step(shift_en), .last(cnt_last)
    );

    ser20_shift #(.WORD_W(WORD_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .load(load), .shift_en(shift_en),
        .din(tx_word), .head(head)
    );

    assign ser_p = drive ? head : 1'b1;
    assign ser_n = ~ser_p;
endmodule

// File: rtl/ser20_tx_chk.sv
module ser20_tx_chk #(
    parameter int WORD_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_stb,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_en_n,
    input logic              wrap_req,
    input logic              ser_p,
    input logic              ser_n
);
    localparam int GAP_W = $clog2(WORD_W + 1);
    localparam logic [GAP_W-1:0] FULL = GAP_W'(WORD_W);

    logic [GAP_W-1:0]  gap;
    logic [WORD_W-1:0] shadow;
    logic              active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap    <= FULL;
            shadow <= '1;
            active <= 1'b0;
        end else if (word_stb) begin
            gap    <= '0;
            shadow <= tx_word;
            active <= !tx_en_n && !wrap_req;
        end else if (gap < FULL) begin
            gap <= gap + 1'b1;
        end
    end

    // R5
    idle_on_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb && (tx_en_n || wrap_req) |=> ser_p && !ser_n);

    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb && !tx_en_n && !wrap_req |=> ser_p == $past(tx_word[0]));

    // R3
    bit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && (gap < FULL) |-> ser_p == shadow[gap]);

    // R7
    gated_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> ser_p);

    // R8
    drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap == FULL |-> ser_p);
endmodule

bind ser20_tx ser20_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .tx_word(tx_word),
    .tx_en_n(tx_en_n), .wrap_req(wrap_req), .ser_p(ser_p), .ser_n(ser_n)
);

// File: tb/sim_ser20_tx.sv
module sim_ser20_tx;
    localparam int W = 20;

    typedef struct packed {
        logic [W-1:0] w;
        logic         en_n;
        logic         wrap;
        logic [4:0]   flip;   // 31 = no toggle of tx_en_n inside the word
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{20'hAA97C, 1'b0, 1'b0, 5'd31, 4'd3},  // R3 comma-like first char
        '{20'h00001, 1'b0, 1'b0, 5'd31, 4'd2},  // R2 bit 0 first
        '{20'h80000, 1'b0, 1'b0, 5'd31, 4'd4},  // R4 bit 19 last, no gap
        '{20'hFFFFE, 1'b0, 1'b1, 5'd31, 4'd5},  // R5 wrap blocks
        '{20'h12345, 1'b1, 1'b0, 5'd31, 4'd5},  // R5 disable blocks
        '{20'h0F0F0, 1'b0, 1'b0, 5'd31, 4'd6},  // R6 fresh word, not stale
        '{20'h5A5A5, 1'b0, 1'b0, 5'd7,  4'd7},  // R7 disable mid-word
        '{20'h33333, 1'b1, 1'b0, 5'd3,  4'd7},  // R7 enable mid-slot
        '{20'h6B3D1, 1'b0, 1'b0, 5'd31, 4'd4}   // R4
    };

    logic clk = 0, rst_n = 0, word_stb = 0, tx_en_n = 1, wrap_req = 0;
    logic [W-1:0] tx_word = '0;
    logic ser_p, ser_n;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ser20_tx u0 (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .tx_word(tx_word),
        .tx_en_n(tx_en_n), .wrap_req(wrap_req), .ser_p(ser_p), .ser_n(ser_n)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(input vec_t v);
        logic [W-1:0] got, exp;
        logic inv_ok;
        bit go;
        go = !v.en_n && !v.wrap;
        word_stb = 1; tx_word = v.w; tx_en_n = v.en_n; wrap_req = v.wrap;
        got = '0; inv_ok = 1;
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            if (k == 0) word_stb = 0;
            got[k] = ser_p;
            if (ser_n !== ~ser_p) inv_ok = 0;
            if (k == int'(v.flip)) tx_en_n = ~tx_en_n;
        end
        exp = go ? v.w : '1;
        chk(got === exp, $sformatf("R%0d", v.req), got, exp);
        chk(inv_ok, "R9", {19'b0, inv_ok}, {19'b0, 1'b1});
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(ser_p === 1'b1 && ser_n === 1'b0, "R1", {18'b0, ser_p, ser_n}, 20'h2);
        rst_n = 1; tx_en_n = 0;
        @(negedge clk);
        // R1 after release
        chk(ser_p === 1'b1 && ser_n === 1'b0, "R1", {18'b0, ser_p, ser_n}, 20'h2);

        // table walk, strobes exactly 20 cycles apart (R2 R3 R4 R5 R6 R7 R9)
        for (int i = 0; i < NV; i++) send_word(VECS[i]);

        // R8: no strobe after the last word
        begin
            logic [W-1:0] tail;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                tail[k] = ser_p;
            end
            chk(tail[4:0] === 5'h1F, "R8", {15'b0, tail[4:0]}, 20'h1F);
        end

        // R1: reset in the middle of a word
        tx_en_n = 0; wrap_req = 0; tx_word = 20'h00000; word_stb = 1;
        @(negedge clk); word_stb = 0;
        repeat (3) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(ser_p === 1'b1 && ser_n === 1'b0, "R1", {18'b0, ser_p, ser_n}, 20'h2);
        rst_n = 1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule